// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker translates a 64-bit linear address into a physical address. It reads translation entries from memory, one level after another, through a four-level tree of tables. A request carries the linear address and the physical base of the top table. The block accepts it when idle and derives each table index from a 9-bit slice of the address. It fetches one 64-bit entry per level over a request/response memory port.

The walk ends when one of these happens:
- a level-1 entry maps a 4KB page;
- a level-3 entry with its large-page bit set maps a 1GB page;
- a level-2 entry with its large-page bit set maps a 2MB page;
- a fetched entry is not present.

A linear address whose upper bits are not a sign extension of bit 47 is refused at once, without any memory read. Each result is marked by a one-cycle `done` pulse. That pulse carries the physical address, the page size, the level where the walk ended and two fault flags. Only one walk is in flight at a time.

Top module: `page_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `done` and `mem_req_valid` are 0.
- R2: A request whose bits 63:48 are not all equal to bit 47 completes with `done`=1 and `resp_noncanon`=1. This happens in the cycle after acceptance, with `resp_level`=0, and no memory read is issued.
- R3: Each entry read address is the table base plus the index times 8. For level 4, the table base is `req_root` with its low 12 bits cleared; for lower levels, it is bits 51:12 of the previous entry. The index comes from linear bits 47:39 for level 4, 38:30 for level 3, 29:21 for level 2 and 20:12 for level 1.
- R4: A present level-1 entry ends the walk with `resp_size`=0 (4KB) and `resp_level`=1. The physical address is entry bits 51:12 followed by linear bits 11:0. Entry bits 63:52 and entry bit 7 at this level have no effect.
- R5: A present level-3 entry with bit 7 set ends the walk after 2 reads, with `resp_size`=2 (1GB) and `resp_level`=3. The physical address is entry bits 51:30 followed by linear bits 29:0; entry bits 29:12 are ignored.
- R6: A present level-2 entry with bit 7 set ends the walk after 3 reads, with `resp_size`=1 (2MB) and `resp_level`=2. The physical address is entry bits 51:21 followed by linear bits 20:0.
- R7: An entry with bit 0 equal to 0 ends the walk with `resp_fault`=1 and `resp_level` set to the level of that entry (4, 3, 2 or 1). No further read is issued.
- R8: Bit 7 of a level-4 entry has no effect; the walk continues to level 3.
- R9: `done` is high for exactly one cycle per walk. While a walk is in flight, `req_ready` is 0, and `mem_req_valid` is 0 whenever `req_ready` is 1.
- R10: Once `mem_req_valid` is raised, it stays high with an unchanged `mem_req_addr` until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_lin | input | 64 | Linear address to translate |
| req_root | input | 52 | Physical base of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Fetched entry |
| done | output | 1 | One-cycle result strobe |
| resp_pa | output | 52 | Translated physical address |
| resp_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| resp_level | output | 3 | Level where the walk ended (0 for non-canonical) |
| resp_fault | output | 1 | Not-present entry met |
| resp_noncanon | output | 1 | Request refused as non-canonical |

## Verification
The properties assume three things about the memory side:
- `mem_rsp_valid` is raised only for a read that has been accepted and is still outstanding;
- there is exactly one response per read;
- the fetched entries form a consistent tree.

The bench's memory model follows these rules. It accepts a read only when `mem_req_ready` is high, and that signal toggles every cycle so that request holding is exercised. It answers exactly once, a fixed two cycles after accepting the read. All requests are driven only while `req_ready` is high, and `req_valid` is dropped right after acceptance.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 9;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int LEVELS   = 4,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int LVL_W    = 3
) (
  input  logic [PA_W-PG_SHIFT-1:0] base,
  input  logic [VA_W-1:0]          lin,
  input  logic [LVL_W-1:0]         lvl,
  output logic [PA_W-1:0]          addr
);
  localparam int ESZ_SH = PG_SHIFT - IDX_W;

  logic [IDX_W-1:0] idx_tab [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tab[g] = lin[PG_SHIFT + IDX_W*(g+1) - 1 -: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i + 1)) idx = idx_tab[i];
    end
  end

  assign addr = {base, idx, {ESZ_SH{1'b0}}};

  logic unused_lo;
  assign unused_lo = ^lin[PG_SHIFT-1:0];
endmodule

// File: rtl/pw_compose.sv
module pw_compose #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int ENT_W    = 64,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [VA_W-1:0]  lin,
  input  logic [1:0]       size,
  output logic [PA_W-1:0]  pa
);
  import pw_pkg::*;
  localparam int SH_2M = PG_SHIFT + IDX_W;
  localparam int SH_1G = PG_SHIFT + 2*IDX_W;

  always_comb begin
    case (size)
      PG_1G:   pa = {entry[PA_W-1:SH_1G], lin[SH_1G-1:0]};
      PG_2M:   pa = {entry[PA_W-1:SH_2M], lin[SH_2M-1:0]};
      default: pa = {entry[PA_W-1:PG_SHIFT], lin[PG_SHIFT-1:0]};
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[PG_SHIFT-1:0], lin[VA_W-1:SH_1G]};
endmodule

// File: rtl/page_walker.sv
module page_walker #(
  parameter int LIN_W  = 64,
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int LEVELS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LIN_W-1:0] req_lin,
  input  logic [PA_W-1:0]  req_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  resp_pa,
  output logic [1:0]       resp_size,
  output logic [2:0]       resp_level,
  output logic             resp_fault,
  output logic             resp_noncanon
);
  import pw_pkg::*;
  localparam int BASE_W = PA_W - PG_SHIFT;
  localparam int LVL_W  = 3;
  localparam int BIT_PS = 7;

  walk_st_e          state_q, state_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [VA_W-1:0]   lin_q, lin_d;
  logic              done_q, done_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic [1:0]        size_q, size_d;
  logic [LVL_W-1:0]  rlvl_q, rlvl_d;
  logic              fault_q, fault_d;
  logic              nc_q, nc_d;
  logic              fin;
  logic [1:0]        cmp_size;
  logic [PA_W-1:0]   cmp_pa;
  logic              canon;

  pw_entry_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS),
    .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_eaddr (
    .base(base_q), .lin(lin_q), .lvl(lvl_q), .addr(mem_req_addr)
  );

  pw_compose #(
    .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W),
    .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W)
  ) u_comp (
    .entry(mem_rsp_data), .lin(lin_q), .size(cmp_size), .pa(cmp_pa)
  );

  assign canon = (&req_lin[LIN_W-1:VA_W-1]) | ~(|req_lin[LIN_W-1:VA_W-1]);

  always_comb begin
    state_d  = state_q;
    lvl_d    = lvl_q;
    base_d   = base_q;
    lin_d    = lin_q;
    done_d   = 1'b0;
    pa_d     = pa_q;
    size_d   = size_q;
    rlvl_d   = rlvl_q;
    fault_d  = fault_q;
    nc_d     = nc_q;
    fin      = 1'b0;
    cmp_size = PG_4K;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          lin_d = req_lin[VA_W-1:0];
          if (!canon) begin
            done_d  = 1'b1;
            nc_d    = 1'b1;
            fault_d = 1'b0;
            rlvl_d  = '0;
            pa_d    = '0;
            size_d  = PG_4K;
          end else begin
            base_d  = req_root[PA_W-1:PG_SHIFT];
            lvl_d   = LVL_W'(LEVELS);
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fin     = 1'b1;
            fault_d = 1'b1;
            pa_d    = '0;
            size_d  = PG_4K;
          end else if (lvl_q == LVL_W'(1)) begin
            fin      = 1'b1;
            cmp_size = PG_4K;
          end else if (lvl_q == LVL_W'(2) && mem_rsp_data[BIT_PS]) begin
            fin      = 1'b1;
            cmp_size = PG_2M;
          end else if (lvl_q == LVL_W'(3) && mem_rsp_data[BIT_PS]) begin
            fin      = 1'b1;
            cmp_size = PG_1G;
          end else begin
            base_d  = mem_rsp_data[PA_W-1:PG_SHIFT];
            lvl_d   = lvl_q - LVL_W'(1);
            state_d = ST_ISSUE;
          end
          if (fin) begin
            done_d  = 1'b1;
            nc_d    = 1'b0;
            rlvl_d  = lvl_q;
            state_d = ST_IDLE;
            if (mem_rsp_data[0]) begin
              fault_d = 1'b0;
              pa_d    = cmp_pa;
              size_d  = cmp_size;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      lin_q   <= '0;
      done_q  <= 1'b0;
      pa_q    <= '0;
      size_q  <= '0;
      rlvl_q  <= '0;
      fault_q <= 1'b0;
      nc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      lin_q   <= lin_d;
      done_q  <= done_d;
      if (done_d) begin
        pa_q    <= pa_d;
        size_q  <= size_d;
        rlvl_q  <= rlvl_d;
        fault_q <= fault_d;
        nc_q    <= nc_d;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign done          = done_q;
  assign resp_pa       = pa_q;
  assign resp_size     = size_q;
  assign resp_level    = rlvl_q;
  assign resp_fault    = fault_q;
  assign resp_noncanon = nc_q;

  logic unused_root;
  assign unused_root = ^req_root[PG_SHIFT-1:0];
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int LIN_W = 64,
  parameter int VA_W  = 48,
  parameter int PA_W  = 52
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LIN_W-1:0] req_lin,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             done,
  input logic [1:0]       resp_size,
  input logic [2:0]       resp_level,
  input logic             resp_fault,
  input logic             resp_noncanon
);
  logic upper_bad;
  assign upper_bad = !((&req_lin[LIN_W-1:VA_W-1]) | ~(|req_lin[LIN_W-1:VA_W-1]));

  AST_NONCANON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && upper_bad) |=> (done && resp_noncanon && resp_level == 3'd0)); // R2
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R3
  AST_HUGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !resp_fault && !resp_noncanon && resp_size == 2'd2) |-> (resp_level == 3'd3)); // R5
  AST_LARGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !resp_fault && !resp_noncanon && resp_size == 2'd1) |-> (resp_level == 3'd2)); // R6
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_fault) |-> (!resp_noncanon && resp_level >= 3'd1 && resp_level <= 3'd4)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
endmodule

bind page_walker page_walker_chk #(.LIN_W(LIN_W), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_lin(req_lin), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .resp_size(resp_size),
  .resp_level(resp_level), .resp_fault(resp_fault), .resp_noncanon(resp_noncanon)
);

// File: tb/page_walker_tb.sv
module page_walker_tb;
  localparam int NV = 13;
  localparam logic [51:0] ROOT = 52'h10000;

  localparam logic [63:0] V_LIN [NV] = '{
    64'h0000_0000_0000_0ABC, 64'h0000_0000_0000_7123, 64'h0000_0000_4000_1234,
    64'h0000_0000_0023_4567, 64'h0000_0000_0040_0000, 64'h0000_0000_0000_3000,
    64'h0000_0080_0000_0000, 64'hFFFF_8000_0000_0ABC, 64'h0001_0000_0000_0000,
    64'hFFFF_0000_0000_0000, 64'h0000_0000_0000_4010, 64'h0000_0100_0000_0ABC,
    64'h0000_0000_8000_0000 };
  localparam logic [51:0] V_PA [NV] = '{
    52'h5ABC, 52'h9123, 52'h8000_1234, 52'h63_4567, 52'h0, 52'h0, 52'h0,
    52'h5ABC, 52'h0, 52'h0, 52'hA010, 52'h5ABC, 52'h0 };
  // kind: 0 translated, 1 not-present fault, 2 non-canonical
  localparam int V_KIND [NV] = '{0,0,0,0,1,1,1,0,2,2,0,0,1};
  localparam int V_SZ   [NV] = '{0,0,2,1,0,0,0,0,0,0,0,0,0};
  localparam int V_LVL  [NV] = '{1,1,3,2,2,1,4,1,0,0,1,1,3};
  localparam int V_RD   [NV] = '{4,4,2,3,3,4,1,4,0,0,4,4,2};
  localparam string V_REQ [NV] = '{"R4","R4","R5","R6","R7","R7","R7","R3","R2","R2","R4","R8","R7"};

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_lin;
  logic [51:0] req_root;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic [51:0] resp_pa;
  logic [1:0]  resp_size;
  logic [2:0]  resp_level;
  logic        resp_fault, resp_noncanon;

  int checks = 0;
  int errors = 0;
  int reads;
  logic [51:0] first_addr;
  logic [63:0] mem [logic [51:0]];

  page_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_root(req_root), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .resp_pa(resp_pa), .resp_size(resp_size), .resp_level(resp_level),
    .resp_fault(resp_fault), .resp_noncanon(resp_noncanon)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_mem(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // memory model: ready toggles, answer two cycles after accepting a read
  initial begin
    int pend = 0;
    logic [51:0] pa_addr = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_mem(pa_addr);
        end
      end
      mem_req_ready = ~mem_req_ready;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        if (reads == 0) first_addr = mem_req_addr;
        reads++;
        pa_addr = mem_req_addr;
        pend = 2;
      end
    end
  end

  task automatic run(input logic [63:0] lin, input logic [51:0] root,
                     output logic ready_mid, output int waited);
    @(negedge clk);
    reads = 0;
    first_addr = '1;
    req_valid = 1'b1;
    req_lin = lin;
    req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    ready_mid = req_ready;
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic rmid;
    int w;
    logic [51:0] exp_first;
    mem[52'h10000] = 64'h11007;
    mem[52'h10010] = 64'h11087;
    mem[52'h10800] = 64'h11007;
    mem[52'h11000] = 64'h12007;
    mem[52'h11008] = 64'hBFFF_F087;
    mem[52'h12000] = 64'h13007;
    mem[52'h12008] = 64'h7F_F087;
    mem[52'h13000] = 64'h5007;
    mem[52'h13018] = 64'h006;
    mem[52'h13020] = 64'hA087;
    mem[52'h13038] = 64'hFFF0_0000_0000_9007;
    reads = 0;
    first_addr = '0;
    req_valid = 1'b0;
    req_lin = '0;
    req_root = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "req_ready in reset", {63'b0, req_ready}, 64'd1);
    check("R1", "done in reset", {63'b0, done}, 64'd0);
    check("R1", "mem_req_valid in reset", {63'b0, mem_req_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "done after reset", {63'b0, done}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      run(V_LIN[i], ROOT, rmid, w);
      check(V_REQ[i], "done seen", {63'b0, done}, 64'd1);
      if (V_KIND[i] == 2) begin
        check("R2", "done at once", w, 0);
        check("R2", "noncanon flag", {63'b0, resp_noncanon}, 64'd1);
        check("R2", "level", resp_level, 0);
      end else begin
        check("R9", "busy during walk", {63'b0, rmid}, 64'd0);
        check(V_REQ[i], "fault flag", {63'b0, resp_fault}, (V_KIND[i] == 1) ? 64'd1 : 64'd0);
        check(V_REQ[i], "noncanon flag", {63'b0, resp_noncanon}, 64'd0);
        check(V_REQ[i], "level", resp_level, V_LVL[i]);
        if (V_KIND[i] == 0) begin
          check(V_REQ[i], "pa", resp_pa, V_PA[i]);
          check(V_REQ[i], "size", resp_size, V_SZ[i]);
        end
        exp_first = ROOT + {34'b0, V_LIN[i][47:39], 3'b000};
        check("R3", "first entry address", first_addr, exp_first);
      end
      check(V_REQ[i], "read count", reads, V_RD[i]);
      @(negedge clk);
      check("R9", "done one cycle", {63'b0, done}, 64'd0);
      check("R7", "no extra reads", reads, V_RD[i]);
    end

    // R3: low 12 bits of the root are ignored
    run(64'h0ABC, ROOT | 52'hABC, rmid, w);
    check("R3", "root low bits pa", resp_pa, 52'h5ABC);
    check("R3", "root low bits addr", first_addr, ROOT);

    // R9: back-to-back walks still give one pulse each
    run(64'h4000_1234, ROOT, rmid, w);
    check("R5", "repeat 1GB pa", resp_pa, 52'h8000_1234);
    run(64'h7123, ROOT, rmid, w);
    check("R4", "after 1GB, 4KB pa", resp_pa, 52'h9123);
    check("R4", "after 1GB, size", resp_size, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule